// File: doc/BRIEF.md
# Soft Reset Generator with Cause Capture

This block is the reset controller of a four-processor system. Software writes request registers over a small byte-wide register bus to pulse a power-on reset (POR) into any single processor, into the whole system, or to pulse an externally-initiated reset (XIR) into chosen processors. A watchdog expiry line, a POR push-button, an XIR push-button, JTAG POR and XIR requests, a remote-monitor request, seven per-agent fatal-error lines and a clock-synthesizer reload arm can all raise resets without software acting. Every reset line is driven by a counter that stretches the request into a pulse of a parameterised length.

Two sticky cause registers record what triggered the most recent POR and the most recent XIR. On each new event the matching register drops its old contents and takes only the causes present in that cycle. After power-up the POR cause shows only the power-up flag. External inputs are taken as already synchronous and act on their rising edge.

Top module: `rstgen_top`

## Requirements
- R1: After reset every reset output is low, the POR cause reads 0x80 (only bit 7, power-up), the XIR cause reads 0, and the watchdog-enable and synthesizer-control registers read 0.
- R2: A write with bit i set (i = 0..3) to the POR request at address 0 drives por_o[i] high for exactly PULSE_LEN cycles, starting the cycle after the write edge, and loads POR cause bit i.
- R3: Writing bit 4 of the POR request starts a system reset: sys_rst_o and all four por_o go high for PULSE_LEN cycles and POR cause bit 4 is set.
- R4: A write with bit i set (i = 0..3) to the XIR request at address 1 drives xir_o[i] high for PULSE_LEN cycles and loads XIR cause bit i.
- R5: Bit 0 of the watchdog register at address 2 arms the watchdog. A rising edge of wdog_i with bit 0 set starts a system reset and loads POR cause bit 16. With bit 0 clear the edge leaves every output and both cause registers unchanged.
- R6: A rising edge on jtag_por_i, btn_por_i, fatal_i[k] or rmon_i starts a system reset and loads POR cause bit 5, 6, 8+k or 17, in that order. An input held high triggers only once.
- R7: The synthesizer register at address 3 holds a load bit (bit 0) and a reset-arm bit (bit 7). A write that makes both 1 when they were not both 1 starts one system reset and loads POR cause bit 15.
- R8: A rising edge of jtag_xir_i pulses all four xir_o and loads XIR cause bit 4. A rising edge of btn_xir_i does the same and loads XIR cause bit 5.
- R9: The POR cause reads at addresses 4, 5 and 6 (bits 7:0, 15:8, 17:16). The XIR cause reads at address 7. A new event replaces the whole register, and events in the same cycle are all recorded.
- R10: Request registers clear themselves and read 0. Reserved bits read 0 and ignore writes: watchdog bits 7:1, synthesizer bits 6:1, address 6 bits 7:2 and address 7 bits 7:6.
- R11: A new trigger on a lane that is already pulsing restarts its count, so the pulse ends PULSE_LEN cycles after the latest trigger. No output rises without a trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | Write qualifier for the access |
| bus_addr_i | input | 3 | Byte address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i (combinational) |
| wdog_i | input | 1 | Watchdog expiry line |
| btn_por_i | input | 1 | POR push-button |
| btn_xir_i | input | 1 | XIR push-button |
| jtag_por_i | input | 1 | JTAG system reset request |
| jtag_xir_i | input | 1 | JTAG XIR request |
| fatal_i | input | 7 | Fatal-error lines from agents 0..6 |
| rmon_i | input | 1 | Remote-monitor reset request |
| por_o | output | 4 | Per-processor POR pulses |
| sys_rst_o | output | 1 | System reset pulse |
| xir_o | output | 4 | Per-processor XIR pulses |

## Verification
The case that matters is a software request and an external event arriving in the same cycle. For example, a per-processor POR write can land on the same clock as a push-button edge, or an XIR write on the same clock as a JTAG XIR edge. The bench sets both stimuli up at the same falling edge so that one rising edge samples them together. It then expects the cause register to hold both bits, and every affected lane to start on that edge. A behavioural model of counters and cause words is compared with every output and with the read data on every clock.

// File: rtl/rstgen_pkg.sv
// Package: shared constants for the soft reset generator.
// Holds the register addresses, the cause-bit positions and the cause types.
// The cause-bit positions are decoded by software and must not move.
package rstgen_pkg;
    localparam int NCPU    = 4;
    localparam int NFATAL  = 7;
    localparam int BUS_AW  = 3;
    localparam int BUS_DW  = 8;
    localparam int PC_W    = 18;
    localparam int XC_W    = 6;

    localparam logic [BUS_AW-1:0] A_POR_REQ = 3'd0;
    localparam logic [BUS_AW-1:0] A_XIR_REQ = 3'd1;
    localparam logic [BUS_AW-1:0] A_WDOG    = 3'd2;
    localparam logic [BUS_AW-1:0] A_SYNTH   = 3'd3;
    localparam logic [BUS_AW-1:0] A_PC_LO   = 3'd4;
    localparam logic [BUS_AW-1:0] A_PC_MID  = 3'd5;
    localparam logic [BUS_AW-1:0] A_PC_HI   = 3'd6;
    localparam logic [BUS_AW-1:0] A_XC      = 3'd7;

    localparam int PC_SYS    = 4;
    localparam int PC_JTAG   = 5;
    localparam int PC_BTN    = 6;
    localparam int PC_PWRUP  = 7;
    localparam int PC_FATAL0 = 8;
    localparam int PC_SYNTH  = 15;
    localparam int PC_WDOG   = 16;
    localparam int PC_RMON   = 17;

    localparam int XC_JTAG   = 4;
    localparam int XC_BTN    = 5;

    typedef logic [PC_W-1:0] por_cause_t;
    typedef logic [XC_W-1:0] xir_cause_t;

    localparam por_cause_t PC_RESET_VAL = por_cause_t'(1) << PC_PWRUP;
endpackage

// File: rtl/rstgen_regs.sv
// Module: host register file.
// Decodes byte writes into one-cycle request strobes, holds the watchdog arm
// and synthesizer control bits, and muxes read data. Assumes a single-cycle
// bus with combinational read data; the request registers read as zero.
module rstgen_regs
    import rstgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en_i,
    input  logic              bus_we_i,
    input  logic [BUS_AW-1:0] bus_addr_i,
    input  logic [BUS_DW-1:0] bus_wdata_i,
    input  por_cause_t        por_cause_i,
    input  xir_cause_t        xir_cause_i,
    output logic [NCPU:0]     por_req_o,
    output logic [NCPU-1:0]   xir_req_o,
    output logic              wd_en_o,
    output logic              synth_trig_o,
    output logic [BUS_DW-1:0] bus_rdata_o
);
    logic wr;
    logic wd_en_q;
    logic ld_q, arm_q, ld_d, arm_d;
    logic unused_wbits;

    assign wr           = bus_en_i & bus_we_i;
    assign unused_wbits = ^bus_wdata_i[6:5];

    // Turn writes to the request addresses into one-cycle strobes.
    always_comb begin
        por_req_o = '0;
        xir_req_o = '0;
        if (wr && bus_addr_i == A_POR_REQ) por_req_o = bus_wdata_i[NCPU:0];
        if (wr && bus_addr_i == A_XIR_REQ) xir_req_o = bus_wdata_i[NCPU-1:0];
    end

    // Next value of the synthesizer control bits.
    always_comb begin
        ld_d  = ld_q;
        arm_d = arm_q;
        if (wr && bus_addr_i == A_SYNTH) begin
            ld_d  = bus_wdata_i[0];
            arm_d = bus_wdata_i[7];
        end
    end

    // Fire only when both bits become 1 together.
    assign synth_trig_o = ld_d & arm_d & ~(ld_q & arm_q);

    // Hold the watchdog arm and the synthesizer control bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wd_en_q <= 1'b0;
            ld_q    <= 1'b0;
            arm_q   <= 1'b0;
        end else begin
            if (wr && bus_addr_i == A_WDOG) wd_en_q <= bus_wdata_i[0];
            ld_q  <= ld_d;
            arm_q <= arm_d;
        end
    end

    assign wd_en_o = wd_en_q;

    // Read multiplexer; reserved and request locations return zero.
    always_comb begin
        case (bus_addr_i)
            A_WDOG:   bus_rdata_o = {7'b0, wd_en_q};
            A_SYNTH:  bus_rdata_o = {arm_q, 6'b0, ld_q};
            A_PC_LO:  bus_rdata_o = por_cause_i[7:0];
            A_PC_MID: bus_rdata_o = por_cause_i[15:8];
            A_PC_HI:  bus_rdata_o = {6'b0, por_cause_i[17:16]};
            A_XC:     bus_rdata_o = {2'b0, xir_cause_i};
            default:  bus_rdata_o = '0;
        endcase
    end

    AST_SYNTH_SINGLE_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        synth_trig_o |=> !synth_trig_o); // R7
endmodule

// File: rtl/rstgen_evt.sv
// Module: event collector.
// Detects rising edges on the external request lines and merges them with the
// software strobes into per-cycle POR and XIR cause vectors. Assumes all
// inputs are already synchronous to clk.
module rstgen_evt
    import rstgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCPU:0]     por_req_i,
    input  logic [NCPU-1:0]   xir_req_i,
    input  logic              wd_en_i,
    input  logic              synth_trig_i,
    input  logic              wdog_i,
    input  logic              btn_por_i,
    input  logic              btn_xir_i,
    input  logic              jtag_por_i,
    input  logic              jtag_xir_i,
    input  logic [NFATAL-1:0] fatal_i,
    input  logic              rmon_i,
    output por_cause_t        por_set_o,
    output xir_cause_t        xir_set_o
);
    localparam int NLINE = NFATAL + 6;

    logic [NLINE-1:0] line, line_q, rise;

    assign line = {fatal_i, rmon_i, wdog_i, btn_xir_i, jtag_xir_i, btn_por_i, jtag_por_i};

    // Remember each line's previous level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= '0;
        else        line_q <= line;
    end

    assign rise = line & ~line_q;

    // Assemble the POR cause bits present in this cycle.
    always_comb begin
        por_set_o                          = '0;
        por_set_o[NCPU:0]                  = por_req_i;
        por_set_o[PC_JTAG]                 = rise[0];
        por_set_o[PC_BTN]                  = rise[1];
        por_set_o[PC_FATAL0 +: NFATAL]     = rise[NLINE-1 -: NFATAL];
        por_set_o[PC_SYNTH]                = synth_trig_i;
        por_set_o[PC_WDOG]                 = rise[4] & wd_en_i;
        por_set_o[PC_RMON]                 = rise[5];
    end

    // Assemble the XIR cause bits present in this cycle.
    always_comb begin
        xir_set_o             = '0;
        xir_set_o[NCPU-1:0]   = xir_req_i;
        xir_set_o[XC_JTAG]    = rise[2];
        xir_set_o[XC_BTN]     = rise[3];
    end

    AST_HELD_LINE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (por_set_o[PC_BTN]) |=> (!por_set_o[PC_BTN])); // R6
endmodule

// File: rtl/rstgen_cause.sv
// Module: sticky cause capture.
// On any cycle with at least one cause present, the register is replaced by
// exactly that cause set; otherwise it holds. Reset leaves only power-up.
module rstgen_cause
    import rstgen_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  por_cause_t por_set_i,
    input  xir_cause_t xir_set_i,
    output por_cause_t por_cause_o,
    output xir_cause_t xir_cause_o
);
    // Replace each cause word when its event set is non-empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            por_cause_o <= PC_RESET_VAL;
            xir_cause_o <= '0;
        end else begin
            if (|por_set_i) por_cause_o <= por_set_i;
            if (|xir_set_i) xir_cause_o <= xir_set_i;
        end
    end

    AST_POWERUP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (por_cause_o == PC_RESET_VAL)); // R1
    AST_CAUSE_NEVER_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        por_cause_o != '0); // R9
endmodule

// File: rtl/rstgen_pulse.sv
// Module: reset pulse stretcher.
// A load starts (or restarts) a down-counter of LEN cycles; the output is
// high while the counter is non-zero. Assumes LEN >= 1.
module rstgen_pulse #(
    parameter int LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic pulse_o
);
    localparam int CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] LOADV = CW'(LEN);

    logic [CW-1:0] cnt_q;

    // Reload on a trigger, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= '0;
        else if (load_i)      cnt_q <= LOADV;
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign pulse_o = (cnt_q != '0);

    AST_PULSE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> pulse_o); // R2
    AST_NO_SPONTANEOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !pulse_o) |=> !pulse_o); // R11
endmodule

// File: rtl/rstgen_top.sv
// Module: soft reset generator top.
// Ties the register file, event collector, cause capture and one pulse
// stretcher per reset lane together. A system event loads the system lane
// and every processor POR lane; a global XIR event loads every XIR lane.
module rstgen_top
    import rstgen_pkg::*;
#(
    parameter int PULSE_LEN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en_i,
    input  logic              bus_we_i,
    input  logic [2:0]        bus_addr_i,
    input  logic [7:0]        bus_wdata_i,
    output logic [7:0]        bus_rdata_o,
    input  logic              wdog_i,
    input  logic              btn_por_i,
    input  logic              btn_xir_i,
    input  logic              jtag_por_i,
    input  logic              jtag_xir_i,
    input  logic [6:0]        fatal_i,
    input  logic              rmon_i,
    output logic [3:0]        por_o,
    output logic              sys_rst_o,
    output logic [3:0]        xir_o
);
    logic [NCPU:0]   por_req;
    logic [NCPU-1:0] xir_req;
    logic            wd_en, synth_trig, sys_evt, xir_all;
    por_cause_t      por_set, por_cause;
    xir_cause_t      xir_set, xir_cause;

    rstgen_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_en_i(bus_en_i), .bus_we_i(bus_we_i),
        .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
        .por_cause_i(por_cause), .xir_cause_i(xir_cause),
        .por_req_o(por_req), .xir_req_o(xir_req),
        .wd_en_o(wd_en), .synth_trig_o(synth_trig),
        .bus_rdata_o(bus_rdata_o)
    );

    rstgen_evt u_evt (
        .clk(clk), .rst_n(rst_n),
        .por_req_i(por_req), .xir_req_i(xir_req),
        .wd_en_i(wd_en), .synth_trig_i(synth_trig),
        .wdog_i(wdog_i), .btn_por_i(btn_por_i), .btn_xir_i(btn_xir_i),
        .jtag_por_i(jtag_por_i), .jtag_xir_i(jtag_xir_i),
        .fatal_i(fatal_i), .rmon_i(rmon_i),
        .por_set_o(por_set), .xir_set_o(xir_set)
    );

    rstgen_cause u_cause (
        .clk(clk), .rst_n(rst_n),
        .por_set_i(por_set), .xir_set_i(xir_set),
        .por_cause_o(por_cause), .xir_cause_o(xir_cause)
    );

    // Any cause above the per-processor bits is a whole-system reset.
    assign sys_evt = |por_set[PC_W-1:PC_SYS];
    assign xir_all = xir_set[XC_JTAG] | xir_set[XC_BTN];

    rstgen_pulse #(.LEN(PULSE_LEN)) u_sys_lane (
        .clk(clk), .rst_n(rst_n), .load_i(sys_evt), .pulse_o(sys_rst_o)
    );

    for (genvar i = 0; i < NCPU; i++) begin : g_lane
        rstgen_pulse #(.LEN(PULSE_LEN)) u_por_lane (
            .clk(clk), .rst_n(rst_n),
            .load_i(por_set[i] | sys_evt), .pulse_o(por_o[i])
        );
        rstgen_pulse #(.LEN(PULSE_LEN)) u_xir_lane (
            .clk(clk), .rst_n(rst_n),
            .load_i(xir_set[i] | xir_all), .pulse_o(xir_o[i])
        );
    end

    AST_SYS_COVERS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_o |-> (&por_o)); // R3
    AST_XIR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (|xir_o) |-> (xir_cause != '0)); // R4
    AST_WDOG_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        (por_cause[PC_WDOG] && !$stable(por_cause)) |-> $past(wd_en)); // R5
endmodule

// File: tb/rstgen_top_tb_top.sv
`timescale 1ns/1ps
module rstgen_top_tb_top;
    localparam int L = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 0, we = 0;
    logic [2:0] addr = 0;
    logic [7:0] wdata = 0, rdata;
    logic wdog = 0, bpor = 0, bxir = 0, jpor = 0, jxir = 0, rmon = 0;
    logic [6:0] fatal = 0;
    logic [3:0] por, xir;
    logic sys;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    rstgen_top #(.PULSE_LEN(L)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_en_i(en), .bus_we_i(we),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .wdog_i(wdog), .btn_por_i(bpor), .btn_xir_i(bxir),
        .jtag_por_i(jpor), .jtag_xir_i(jxir), .fatal_i(fatal), .rmon_i(rmon),
        .por_o(por), .sys_rst_o(sys), .xir_o(xir)
    );

    // Behavioural reference model state.
    int pc_cnt[4], xc_cnt[4], s_cnt;
    logic [17:0] m_pc;
    logic [5:0]  m_xc;
    logic m_wd, m_ld, m_arm;
    logic [12:0] m_prev;

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] m_read(logic [2:0] a);
        case (a)
            3'd2: return {7'b0, m_wd};
            3'd3: return {m_arm, 6'b0, m_ld};
            3'd4: return m_pc[7:0];
            3'd5: return m_pc[15:8];
            3'd6: return {6'b0, m_pc[17:16]};
            3'd7: return {2'b0, m_xc};
            default: return 8'h00;
        endcase
    endfunction

    // Model update at each rising edge, then compare every output 1 ns later.
    always @(posedge clk) begin
        logic [12:0] cur, rise;
        logic [17:0] ps;
        logic [5:0]  xs;
        logic nld, narm, wr, sysv, xall;
        cur = {fatal, rmon, wdog, bxir, jxir, bpor, jpor};
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin pc_cnt[i] = 0; xc_cnt[i] = 0; end
            s_cnt = 0; m_pc = 18'h80; m_xc = 0; m_wd = 0; m_ld = 0; m_arm = 0; m_prev = 0;
        end else begin
            rise = cur & ~m_prev;
            wr = en && we;
            ps = 0; xs = 0;
            nld = m_ld; narm = m_arm;
            if (wr && addr == 3'd3) begin nld = wdata[0]; narm = wdata[7]; end
            if (wr && addr == 3'd0) ps[4:0] = wdata[4:0];
            if (wr && addr == 3'd1) xs[3:0] = wdata[3:0];
            ps[5] = rise[0]; ps[6] = rise[1];
            ps[14:8] = rise[12:6];
            ps[15] = nld && narm && !(m_ld && m_arm);
            ps[16] = rise[4] && m_wd;
            ps[17] = rise[5];
            xs[4] = rise[2]; xs[5] = rise[3];
            sysv = |ps[17:4];
            xall = xs[4] | xs[5];
            for (int i = 0; i < 4; i++) begin
                if (ps[i] || sysv) pc_cnt[i] = L; else if (pc_cnt[i] > 0) pc_cnt[i]--;
                if (xs[i] || xall) xc_cnt[i] = L; else if (xc_cnt[i] > 0) xc_cnt[i]--;
            end
            if (sysv) s_cnt = L; else if (s_cnt > 0) s_cnt--;
            if (ps != 0) m_pc = ps;
            if (xs != 0) m_xc = xs;
            if (wr && addr == 3'd2) m_wd = wdata[0];
            m_ld = nld; m_arm = narm;
            m_prev = cur;
        end
        #1;
        if (rst_n && !done) begin
            for (int i = 0; i < 4; i++) begin
                chk("R2/R3/R11", $sformatf("por_o[%0d]", i), por[i], pc_cnt[i] != 0);
                chk("R4/R8/R11", $sformatf("xir_o[%0d]", i), xir[i], xc_cnt[i] != 0);
            end
            chk("R3/R5/R6/R7", "sys_rst_o", sys, s_cnt != 0);
            chk("R9/R10", $sformatf("rdata@%0d", addr), rdata, m_read(addr));
        end
    end

    task automatic bus_wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk); en = 1; we = 1; addr = a; wdata = d;
        @(negedge clk); en = 0; we = 0;
    endtask

    task automatic rd_chk(string req, logic [2:0] a, int exp);
        @(negedge clk); addr = a; #1;
        chk(req, $sformatf("read addr %0d", a), rdata, exp);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            done = 1; n_chk++; n_fail++;
            $display("FAIL watchdog: run hung, actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        @(negedge clk); #1;
        chk("R1", "por_o", por, 0); chk("R1", "xir_o", xir, 0); chk("R1", "sys", sys, 0);
        rd_chk("R1", 3'd4, 8'h80); rd_chk("R1", 3'd5, 0); rd_chk("R1", 3'd6, 0);
        rd_chk("R1", 3'd7, 0); rd_chk("R1", 3'd2, 0); rd_chk("R1", 3'd3, 0);
        // R2: single-CPU POR, pulse length
        bus_wr(3'd0, 8'h04);
        #1; chk("R2", "por_o after write", por, 4'b0100);
        idle(L - 1); #1; chk("R2", "por_o last cycle", por, 4'b0100);
        idle(1); #1; chk("R2", "por_o ended", por, 0);
        rd_chk("R2", 3'd4, 8'h04);
        rd_chk("R10", 3'd0, 0);
        // R3: soft system reset
        bus_wr(3'd0, 8'h10); #1; chk("R3", "sys", sys, 1); chk("R3", "por all", por, 4'hF);
        idle(L + 2); rd_chk("R3", 3'd4, 8'h10);
        // R4: XIR requests
        bus_wr(3'd1, 8'hF9); #1; chk("R4", "xir_o", xir, 4'b1001);
        idle(L + 2); rd_chk("R4", 3'd7, 8'h09); rd_chk("R10", 3'd1, 0);
        // R5: watchdog disarmed is ignored
        @(negedge clk); wdog = 1; @(negedge clk); #1;
        chk("R5", "sys while disarmed", sys, 0);
        wdog = 0; rd_chk("R5", 3'd4, 8'h10); rd_chk("R5", 3'd6, 0);
        bus_wr(3'd2, 8'hFF); rd_chk("R10", 3'd2, 8'h01);
        @(negedge clk); wdog = 1; @(negedge clk); #1; chk("R5", "sys armed", sys, 1);
        wdog = 0; idle(L + 2); rd_chk("R5", 3'd6, 8'h01); rd_chk("R9", 3'd4, 0);
        // R6: external system sources
        @(negedge clk); jpor = 1; idle(L + 3); rd_chk("R6", 3'd4, 8'h20);
        @(negedge clk); #1; chk("R6", "held input no retrigger", sys, 0); jpor = 0;
        @(negedge clk); fatal = 7'b0001000; idle(L + 2); rd_chk("R6", 3'd5, 8'h08); fatal = 0;
        @(negedge clk); fatal = 7'b1000000; rmon = 1; idle(L + 2);
        rd_chk("R6", 3'd5, 8'h40); rd_chk("R6", 3'd6, 8'h02); fatal = 0; rmon = 0;
        @(negedge clk); bpor = 1; @(negedge clk); bpor = 0; idle(L + 2); rd_chk("R6", 3'd4, 8'h40);
        // R7: synthesizer arm
        bus_wr(3'd3, 8'hFF); #1; chk("R7", "sys on arm", sys, 1);
        idle(L + 2); rd_chk("R7", 3'd5, 8'h80); rd_chk("R10", 3'd3, 8'h81);
        bus_wr(3'd3, 8'h81); #1; chk("R7", "no refire", sys, 0);
        bus_wr(3'd3, 8'h01); bus_wr(3'd3, 8'h81); #1; chk("R7", "rearm fires", sys, 1);
        idle(L + 2);
        // R8: global XIR sources
        @(negedge clk); jxir = 1; @(negedge clk); jxir = 0; #1; chk("R8", "xir all", xir, 4'hF);
        idle(L + 2); rd_chk("R8", 3'd7, 8'h10);
        @(negedge clk); bxir = 1; @(negedge clk); bxir = 0; idle(L + 2); rd_chk("R8", 3'd7, 8'h20);
        // R9: simultaneous sources
        @(negedge clk); en = 1; we = 1; addr = 3'd0; wdata = 8'h01; bpor = 1;
        @(negedge clk); en = 0; we = 0; bpor = 0; idle(L + 2);
        rd_chk("R9", 3'd4, 8'h41);
        @(negedge clk); en = 1; we = 1; addr = 3'd1; wdata = 8'h02; jxir = 1;
        @(negedge clk); en = 0; we = 0; jxir = 0; idle(L + 2);
        rd_chk("R9", 3'd7, 8'h12);
        // R11: retrigger restarts the count
        bus_wr(3'd0, 8'h02); idle(2); bus_wr(3'd0, 8'h02);
        idle(L - 1); #1; chk("R11", "still high", por, 4'b0010);
        idle(1); #1; chk("R11", "ended", por, 0);
        idle(4);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule